// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block models the controller inside a character display module. It takes bus cycles, each made of a register-select bit, a read/write bit and one byte, and decodes the display instruction set. From these cycles it keeps an address counter, a choice between the character store and the glyph store, the entry direction and auto-shift bits, the display, cursor and blink enables, a horizontal display offset and the interface, line-count and font bits. It holds an 80-byte character store and a 64-byte glyph store internally. Accesses to these stores go through the bus cycles.

Each accepted instruction makes the block busy for a time counted in oscillator periods, and each oscillator period is a parameterised number of system clocks. The status read is the only cycle served during that time. Any other cycle that arrives while busy is dropped and sets a sticky error flag. Data reads go through an output register, so the first read after an address set returns an old value.

Top module: `char_instr_decoder`

## Requirements
- R1: An instruction cycle (register-select 0, write) is decoded by its most significant 1 bit. Bit 7 sets a character-store address, bit 6 sets a glyph-store address, bit 5 is function set, bit 4 is shift, bit 3 is display control, bit 2 is entry mode, bit 1 is home and bit 0 is clear. The lower bits are operands. Code 00h changes nothing and causes no busy time.
- R2: Clear writes 20h to all 80 character locations, sets the address to 00h, selects the character store, sets the entry direction to increment and zeroes the display offset.
- R3: Home sets the address to 00h, selects the character store and zeroes the display offset. Stored characters are left unchanged.
- R4: Entry mode takes the increment bit from bit 1 and the auto-shift bit from bit 0. Display control takes display-on from bit 2, cursor-on from bit 1 and blink-on from bit 0. Function set takes the 8-bit interface bit from bit 4, the two-line bit from bit 3 and the tall-font bit from bit 2.
- R5: The shift instruction reads bit 3 as display/cursor and bit 2 as right/left. With bits 00 the address steps down by one, and with 01 it steps up by one. With 10 the offset goes up by one (display left), and with 11 it goes down by one. A display shift leaves the address unchanged. The offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode.
- R6: In two-line mode the character address steps up 27h to 40h and 67h to 00h, and steps down 40h to 27h and 00h to 67h. Address 40h+k maps to store location 40+k.
- R7: In one-line mode the character address runs from 00h to 4Fh and wraps at both ends.
- R8: A status cycle (register-select 0, read) returns the busy state in bit 7 and the address in bits 6..0. It is served while busy and adds no busy time.
- R9: Data cycles (register-select 1) access the store chosen by the last address set, clear or home. After each access the address steps by one in the entry direction. Glyph-store addresses wrap within 6 bits.
- R10: A data read returns the output register. The output register is then loaded with the byte at the current address, before the address steps. A cursor shift with the character store selected loads the output register with the byte at the new address.
- R11: Busy lasts LONG_OSC oscillator periods for clear and home, DATA_OSC for data accesses and SHORT_OSC for other instructions. Each oscillator period is CLKS_PER_OSC clocks.
- R12: A non-status cycle that arrives while busy has no effect and sets the error flag. Only reset clears the error flag.
- R13: A data write with auto-shift on moves the display offset up by one if the entry direction is increment and down by one if it is decrement.
- R14: After reset the store holds 20h in every character location. The address is 00h, the direction is increment, the 8-bit interface bit is 1, all other mode bits are 0 and the offset is 0. The block is not busy and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One-cycle strobe for a bus cycle |
| cyc_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| cyc_rw | input | 1 | 1 read, 0 write |
| cyc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Byte returned by the last accepted read |
| busy | output | 1 | Execution in progress |
| err_flag | output | 1 | Sticky flag for a cycle dropped while busy |
| cg_select | output | 1 | 1 when the glyph store is the data target |
| entry_inc | output | 1 | Entry direction, 1 increments |
| entry_shift | output | 1 | Auto display shift on write |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| bus_8bit | output | 1 | Interface width bit |
| two_line | output | 1 | Two-line addressing mode |
| tall_font | output | 1 | Tall font bit |
| shift_ofs | output | 7 | Display offset in characters |

## Verification
The bench steps the address across every line boundary in both directions and in both line modes. A design with the wrong wrap would report 28h or 68h in a status read, or would write the character into the wrong line. It reads back immediately after an address set. A design without the output-register pipeline returns fresh data on the first read and fails the stale-value check. It measures the busy length of each instruction class and sends cycles into a busy window. A decoder that accepts those cycles changes the mode bits or leaves the error flag low. Random mixes of writes, reads, cursor and display shifts and mode changes are compared with a reference model after every operation.

// File: rtl/char_instr_decoder.sv
module char_instr_decoder #(
  parameter int CLKS_PER_OSC = 4,
  parameter int LONG_OSC     = 413,
  parameter int SHORT_OSC    = 11,
  parameter int DATA_OSC     = 12,
  parameter int DD_DEPTH     = 80,
  parameter int CG_DEPTH     = 64,
  parameter int LINE_LEN     = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_valid,
  input  logic       cyc_rs,
  input  logic       cyc_rw,
  input  logic [7:0] cyc_wdata,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       err_flag,
  output logic       cg_select,
  output logic       entry_inc,
  output logic       entry_shift,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus_8bit,
  output logic       two_line,
  output logic       tall_font,
  output logic [6:0] shift_ofs
);
  localparam int LONG_C  = LONG_OSC * CLKS_PER_OSC;
  localparam int SHORT_C = SHORT_OSC * CLKS_PER_OSC;
  localparam int DATA_C  = DATA_OSC * CLKS_PER_OSC;
  localparam int CW      = $clog2(LONG_C + 1);
  localparam int CGW     = $clog2(CG_DEPTH);

  logic [7:0]    dd [DD_DEPTH];
  logic [7:0]    cg [CG_DEPTH];
  logic [6:0]    ac;
  logic [7:0]    out_reg;
  logic [CW-1:0] cnt;

  function automatic logic [6:0] step_addr(input logic [6:0] a, input logic up,
                                           input logic cgm, input logic two);
    if (cgm)
      return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (two) begin
      if (up) return (a == 7'h27) ? 7'h40 : (a == 7'h67) ? 7'h00 : a + 7'd1;
      return (a == 7'h40) ? 7'h27 : (a == 7'h00) ? 7'h67 : a - 7'd1;
    end
    if (up) return (a >= 7'h4F) ? 7'h00 : a + 7'd1;
    return (a == 7'h00) ? 7'h4F : a - 7'd1;
  endfunction

  function automatic logic [6:0] dd_index(input logic [6:0] a, input logic two);
    if (!two) return a;
    return a[6] ? {1'b0, a[5:0]} + 7'(LINE_LEN) : {1'b0, a[5:0]};
  endfunction

  function automatic logic [6:0] ofs_step(input logic [6:0] o, input logic left,
                                          input logic [6:0] span);
    if (left) return (o >= span - 7'd1) ? 7'd0 : o + 7'd1;
    return (o == 7'd0) ? span - 7'd1 : o - 7'd1;
  endfunction

  logic [6:0] span, cur_idx, sh_ac, sh_idx, acc_next;
  logic [7:0] cur_byte, sh_byte;
  logic       status_rd, instr_ok, data_ok;

  assign busy      = (cnt != '0);
  assign status_rd = !cyc_rs && cyc_rw;
  assign instr_ok  = cyc_valid && !busy && !cyc_rs && !cyc_rw;
  assign data_ok   = cyc_valid && !busy && cyc_rs;
  assign span      = two_line ? 7'(LINE_LEN) : 7'(DD_DEPTH);
  assign cur_idx   = dd_index(ac, two_line);
  assign cur_byte  = cg_select ? cg[ac[CGW-1:0]]
                   : (cur_idx < 7'(DD_DEPTH)) ? dd[cur_idx] : 8'h20;
  assign acc_next  = step_addr(ac, entry_inc, cg_select, two_line);
  assign sh_ac     = step_addr(ac, cyc_wdata[2], cg_select, two_line);
  assign sh_idx    = dd_index(sh_ac, two_line);
  assign sh_byte   = (sh_idx < 7'(DD_DEPTH)) ? dd[sh_idx] : 8'h20;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_DEPTH; i++) dd[i] <= 8'h20;
      for (int i = 0; i < CG_DEPTH; i++) cg[i] <= 8'h00;
      ac <= '0; out_reg <= '0; rd_data <= '0; cnt <= '0; err_flag <= 1'b0;
      cg_select <= 1'b0; entry_inc <= 1'b1; entry_shift <= 1'b0;
      disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0;
      bus_8bit <= 1'b1; two_line <= 1'b0; tall_font <= 1'b0; shift_ofs <= '0;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (cyc_valid && status_rd)
        rd_data <= {busy, ac};
      else if (cyc_valid && busy)
        err_flag <= 1'b1;

      if (data_ok) begin
        cnt <= CW'(DATA_C);
        ac  <= acc_next;
        if (cyc_rw) begin
          rd_data <= out_reg;
          out_reg <= cur_byte;
        end else begin
          if (cg_select) cg[ac[CGW-1:0]] <= cyc_wdata;
          else if (cur_idx < 7'(DD_DEPTH)) dd[cur_idx] <= cyc_wdata;
          if (entry_shift) shift_ofs <= ofs_step(shift_ofs, entry_inc, span);
        end
      end

      if (instr_ok) begin
        casez (cyc_wdata)
          8'b1???????: begin
            cnt <= CW'(SHORT_C); ac <= cyc_wdata[6:0]; cg_select <= 1'b0;
          end
          8'b01??????: begin
            cnt <= CW'(SHORT_C); ac <= {1'b0, cyc_wdata[5:0]}; cg_select <= 1'b1;
          end
          8'b001?????: begin
            cnt <= CW'(SHORT_C);
            bus_8bit <= cyc_wdata[4]; two_line <= cyc_wdata[3]; tall_font <= cyc_wdata[2];
          end
          8'b0001????: begin
            cnt <= CW'(SHORT_C);
            if (cyc_wdata[3])
              shift_ofs <= ofs_step(shift_ofs, !cyc_wdata[2], span);
            else begin
              ac <= sh_ac;
              if (!cg_select) out_reg <= sh_byte;
            end
          end
          8'b00001???: begin
            cnt <= CW'(SHORT_C);
            disp_on <= cyc_wdata[2]; cursor_on <= cyc_wdata[1]; blink_on <= cyc_wdata[0];
          end
          8'b000001??: begin
            cnt <= CW'(SHORT_C);
            entry_inc <= cyc_wdata[1]; entry_shift <= cyc_wdata[0];
          end
          8'b0000001?: begin
            cnt <= CW'(LONG_C); ac <= '0; cg_select <= 1'b0; shift_ofs <= '0;
          end
          8'b00000001: begin
            cnt <= CW'(LONG_C); ac <= '0; cg_select <= 1'b0; shift_ofs <= '0;
            entry_inc <= 1'b1;
            for (int i = 0; i < DD_DEPTH; i++) dd[i] <= 8'h20;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/char_instr_decoder_chk.sv
module char_instr_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_valid,
  input logic       cyc_rs,
  input logic       cyc_rw,
  input logic [7:0] cyc_wdata,
  input logic       busy,
  input logic       err_flag,
  input logic [6:0] ac,
  input logic       cg_select,
  input logic       entry_inc,
  input logic       disp_on,
  input logic [6:0] shift_ofs
);
  logic ins;
  assign ins = cyc_valid && !busy && !cyc_rs && !cyc_rw;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R12

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && busy && !(!cyc_rs && cyc_rw)
    |=> err_flag && $stable(ac) && $stable(cg_select) && $stable(disp_on)); // R12

  AST_STATUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !busy && !cyc_rs && cyc_rw |=> !busy && $stable(ac)); // R8

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ins && cyc_wdata == 8'h01
    |=> busy && ac == 7'h00 && entry_inc && shift_ofs == 7'd0 && !cg_select); // R2

  AST_HOME_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ins && cyc_wdata[7:1] == 7'h01 |=> ac == 7'h00 && shift_ofs == 7'd0 && !cg_select); // R3

  AST_GLYPH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ins && cyc_wdata[7:6] == 2'b01 |=> cg_select && ac == {1'b0, $past(cyc_wdata[5:0])}); // R9

  AST_DISP_SHIFT_AC: assert property (@(posedge clk) disable iff (!rst_n)
    ins && cyc_wdata[7:4] == 4'h1 && cyc_wdata[3] |=> $stable(ac)); // R5

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ins && cyc_wdata == 8'h00 |=> !busy && $stable(ac)); // R1
endmodule

bind char_instr_decoder char_instr_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_rs(cyc_rs), .cyc_rw(cyc_rw),
  .cyc_wdata(cyc_wdata), .busy(busy), .err_flag(err_flag), .ac(ac),
  .cg_select(cg_select), .entry_inc(entry_inc), .disp_on(disp_on), .shift_ofs(shift_ofs)
);

// File: tb/char_instr_decoder_tb_top.sv
`timescale 1ns/1ps
module char_instr_decoder_tb_top;
  localparam int LONGC = 413 * 4, SHORTC = 11 * 4, DATAC = 12 * 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cyc_valid, cyc_rs, cyc_rw;
  logic [7:0] cyc_wdata, rd_data;
  logic busy, err_flag, cg_select, entry_inc, entry_shift, disp_on, cursor_on, blink_on;
  logic bus_8bit, two_line, tall_font;
  logic [6:0] shift_ofs;

  char_instr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_rs(cyc_rs), .cyc_rw(cyc_rw),
    .cyc_wdata(cyc_wdata), .rd_data(rd_data), .busy(busy), .err_flag(err_flag),
    .cg_select(cg_select), .entry_inc(entry_inc), .entry_shift(entry_shift),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .bus_8bit(bus_8bit),
    .two_line(two_line), .tall_font(tall_font), .shift_ofs(shift_ofs)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_dd [80];
  logic [7:0] m_cg [64];
  logic [6:0] m_ac, m_ofs;
  logic [7:0] m_out, m_rd;
  logic m_cgs, m_inc, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f, m_err;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [6:0] m_step(input logic [6:0] a, input logic up);
    if (m_cgs) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (m_n) begin
      if (up) return a == 7'h27 ? 7'h40 : a == 7'h67 ? 7'h00 : a + 7'd1;
      return a == 7'h40 ? 7'h27 : a == 7'h00 ? 7'h67 : a - 7'd1;
    end
    if (up) return a >= 7'h4F ? 7'h00 : a + 7'd1;
    return a == 7'h00 ? 7'h4F : a - 7'd1;
  endfunction

  function automatic int m_idx(input logic [6:0] a);
    if (!m_n) return int'(a);
    return a[6] ? 40 + int'(a[5:0]) : int'(a[5:0]);
  endfunction

  function automatic logic [7:0] m_byte(input logic [6:0] a);
    if (m_cgs) return m_cg[a[5:0]];
    return m_idx(a) < 80 ? m_dd[m_idx(a)] : 8'h20;
  endfunction

  function automatic logic [6:0] m_ostep(input logic [6:0] o, input logic left);
    logic [6:0] sp;
    sp = m_n ? 7'd40 : 7'd80;
    if (left) return o >= sp - 7'd1 ? 7'd0 : o + 7'd1;
    return o == 7'd0 ? sp - 7'd1 : o - 7'd1;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
    for (int i = 0; i < 64; i++) m_cg[i] = 8'h00;
    m_ac = 0; m_ofs = 0; m_out = 0; m_rd = 0; m_cgs = 0; m_inc = 1; m_sh = 0;
    m_d = 0; m_c = 0; m_b = 0; m_dl = 1; m_n = 0; m_f = 0; m_err = 0;
  endtask

  task automatic m_apply(input logic rs, input logic rw, input logic [7:0] d);
    if (rs) begin
      if (rw) begin
        m_rd = m_out; m_out = m_byte(m_ac);
      end else begin
        if (m_cgs) m_cg[m_ac[5:0]] = d;
        else if (m_idx(m_ac) < 80) m_dd[m_idx(m_ac)] = d;
        if (m_sh) m_ofs = m_ostep(m_ofs, m_inc);
      end
      m_ac = m_step(m_ac, m_inc);
    end else if (!rw) begin
      if (d[7]) begin m_ac = d[6:0]; m_cgs = 0; end
      else if (d[6]) begin m_ac = {1'b0, d[5:0]}; m_cgs = 1; end
      else if (d[5]) begin m_dl = d[4]; m_n = d[3]; m_f = d[2]; end
      else if (d[4]) begin
        if (d[3]) m_ofs = m_ostep(m_ofs, !d[2]);
        else begin m_ac = m_step(m_ac, d[2]); if (!m_cgs) m_out = m_byte(m_ac); end
      end
      else if (d[3]) begin m_d = d[2]; m_c = d[1]; m_b = d[0]; end
      else if (d[2]) begin m_inc = d[1]; m_sh = d[0]; end
      else if (d[1]) begin m_ac = 0; m_cgs = 0; m_ofs = 0; end
      else if (d[0]) begin
        m_ac = 0; m_cgs = 0; m_ofs = 0; m_inc = 1;
        for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
      end
    end
  endtask

  task automatic drive(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    cyc_valid = 1; cyc_rs = rs; cyc_rw = rw; cyc_wdata = d;
    @(negedge clk);
    cyc_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic op(input logic rs, input logic rw, input logic [7:0] d);
    wait_idle();
    m_apply(rs, rw, d);
    drive(rs, rw, d);
  endtask

  task automatic check_state(input string r);
    chk({r, " flags"}, {cg_select, entry_inc, entry_shift, disp_on, cursor_on, blink_on,
                        bus_8bit, two_line, tall_font, err_flag},
        {m_cgs, m_inc, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f, m_err});
    chk({r, " offset"}, shift_ofs, m_ofs);
    wait_idle();
    drive(0, 1, 8'h00);
    chk({r, " status"}, rd_data, {1'b0, m_ac});
  endtask

  task automatic data_rd(input string r);
    op(1, 1, 8'h00);
    chk(r, rd_data, m_rd);
  endtask

  task automatic busy_len(input string r, input logic rs, input logic [7:0] d, input int exp);
    int n;
    op(rs, 0, d);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(r, n, exp);
  endtask

  function automatic logic [6:0] rnd_dd();
    if (m_n) return $urandom_range(0, 1) ? 7'h40 + 7'($urandom_range(0, 39))
                                         : 7'($urandom_range(0, 39));
    return 7'($urandom_range(0, 79));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    cyc_valid = 0; cyc_rs = 0; cyc_rw = 0; cyc_wdata = 0; rst_n = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R14 busy", busy, 0);
    check_state("R14");
    data_rd("R14 first read");
    data_rd("R14 blank store");

    // R11 busy lengths
    busy_len("R11 clear", 0, 8'h01, LONGC);
    busy_len("R11 home", 0, 8'h02, LONGC);
    busy_len("R11 entry", 0, 8'h06, SHORTC);
    busy_len("R11 write", 1, 8'h41, DATAC);
    busy_len("R1 zero code", 0, 8'h00, 0);
    check_state("R1 zero code");

    // R4 mode bits
    op(0, 0, 8'h0F); op(0, 0, 8'h3C); op(0, 0, 8'h05);
    check_state("R4 set");
    op(0, 0, 8'h0A); op(0, 0, 8'h28); op(0, 0, 8'h06);
    check_state("R4 mix");

    // R6 two-line wrap (two_line set above)
    op(0, 0, 8'hA7); op(1, 0, 8'h55);
    check_state("R6 27h up");
    op(0, 0, 8'hE7); op(1, 0, 8'h66);
    check_state("R6 67h up");
    op(0, 0, 8'h04); op(0, 0, 8'hC0); op(1, 0, 8'h77);
    check_state("R6 40h down");
    op(1, 0, 8'h78);
    check_state("R6 27h down");
    op(0, 0, 8'h80); op(1, 0, 8'h79);
    check_state("R6 00h down");
    op(0, 0, 8'h06); op(0, 0, 8'hC0);
    data_rd("R10 stale first");
    data_rd("R6 line2 byte");
    op(0, 0, 8'hA7);
    data_rd("R10 stale again");
    data_rd("R6 line1 end byte");

    // R7 one-line wrap
    op(0, 0, 8'h30); op(0, 0, 8'hCF); op(1, 0, 8'h31);
    check_state("R7 4Fh up");
    op(0, 0, 8'h10);
    check_state("R7 00h left");
    op(0, 0, 8'h14);
    data_rd("R10 after cursor shift");

    // R5 and R13 offsets
    op(0, 0, 8'h18); op(0, 0, 8'h1C); op(0, 0, 8'h1C);
    check_state("R5 display shifts");
    op(0, 0, 8'h07); op(1, 0, 8'h21); op(0, 0, 8'h05); op(1, 0, 8'h22);
    check_state("R13 auto shift");
    op(0, 0, 8'h02);
    check_state("R3 home");
    data_rd("R3 store kept");

    // R9 glyph store
    op(0, 0, 8'h06); op(0, 0, 8'h7F); op(1, 0, 8'h1F); op(1, 0, 8'h0E);
    check_state("R9 glyph wrap");
    op(0, 0, 8'h7F); data_rd("R9 stale"); data_rd("R9 glyph 3Fh"); data_rd("R9 glyph 00h");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 25) op(1, 0, 8'($urandom));
      else if (k < 40) data_rd("R10 random read");
      else if (k < 50) op(0, 0, {1'b1, rnd_dd()});
      else if (k < 55) op(0, 0, {2'b01, 6'($urandom)});
      else if (k < 68) op(0, 0, {4'h1, 2'($urandom), 2'b00});
      else if (k < 75) op(0, 0, {5'b00001, 3'($urandom)});
      else if (k < 82) op(0, 0, {6'b000001, 2'($urandom)});
      else if (k < 88) begin
        op(0, 0, {3'b001, 3'($urandom), 2'b00});
        op(0, 0, {1'b1, rnd_dd()});
      end
      else if (k < 96) op(0, 0, 8'h00);
      else if (k < 98) op(0, 0, 8'h02);
      else op(0, 0, 8'h01);
      check_state("R9 random");
    end

    // R8 and R12 during busy
    op(0, 0, 8'h80);
    op(0, 0, 8'h01);
    drive(0, 1, 8'h00);
    chk("R8 status while busy", rd_data, {1'b1, 7'h00});
    drive(0, 0, 8'h0F);
    drive(1, 0, 8'h33);
    m_err = 1;
    wait_idle();
    check_state("R12 dropped");
    data_rd("R2 stale");
    data_rd("R2 cleared store");
    op(0, 0, 8'h02);
    check_state("R12 sticky");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule